// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This controller frees an I2C bus after only the master side has been reset. A slave that was in the middle of a transfer keeps its internal state, and it can go on pulling SDA low and block the bus. A request on `start_i` makes the block run a burst of SCL clock pulses with SDA left released, so that a slave still shifting out data can finish its byte. The block then generates a stop condition and reports whether SDA reads high afterwards.

Both lines are open-drain. The block only ever pulls a line low or lets it go. Each output enable means "pull low". The block samples the real line level through `scl_i` and `sda_i`. If another device stretches the clock by holding SCL low, the block waits: a high phase is timed only from the first cycle in which SCL reads high. The length of each timed phase comes from `half_div_i`, counted in system clocks.

The burst is capped at `PULSES` (16 by default). By default it ends early, after the first pulse at which SDA is found released.

Top module: `i2c_unjam`

## Requirements
- R1: While reset is asserted and right after it is released, `scl_oe_o`, `sda_oe_o`, `busy_o`, `done_o` and `sda_free_o` are all 0, so neither line is pulled.
- R2: A 1 on `start_i` in idle starts a recovery. From the next cycle `busy_o` is 1 and SCL is pulled low. A `start_i` that arrives while `busy_o` is 1 has no effect on the running sequence.
- R3: Each SCL low phase pulls SCL for `half_div_i`+1 cycles and then releases it. It stays low for as long as another device holds it. Each burst high phase keeps SCL released for `half_div_i`+1 cycles, counted after the first cycle in which `scl_i` is sampled high.
- R4: During the burst SDA is never pulled. The burst ends after the pulse whose rising SCL edge finds `sda_i` high, or after 16 pulses, whichever comes first.
- R5: The stop is made in this order. First SCL is pulled low for one cycle with SDA released. Then SDA is pulled while SCL stays low for `half_div_i`+1 more cycles. Then SCL is released. Once `scl_i` reads high, SDA stays pulled for `half_div_i`+1 cycles and is then released while SCL is high. SDA is pulled exactly once per recovery.
- R6: `done_o` is 1 for exactly one cycle per recovery, in the first cycle in which `busy_o` is 0 again.
- R7: `sda_free_o` takes the level of `sda_i` sampled `half_div_i`+1 cycles after SDA was released (1 = line high). It holds that value until the next accepted request, and it reads 0 while `busy_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Recovery request, sampled in idle |
| half_div_i | input | DIV_W | Timed phase length minus one, in clocks |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| busy_o | output | 1 | Recovery in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sda_free_o | output | 1 | SDA read high at the end of the last recovery |

## Verification
The assertions assume that `scl_i` and `sda_i` are already synchronous to `clk`. They also assume that the wired-AND line never reads high while the block itself pulls it low, and that `half_div_i` does not change while a recovery runs. The bench meets these assumptions as follows. It models each line as the AND of the block's release and a modelled slave's release. It updates every slave and stimulus value on the falling clock edge. It sets the divider only before it raises `start_i`. The modelled slave holds SDA low for a chosen number of SCL rising edges and can stretch each low phase by a chosen number of cycles.

// File: rtl/i2c_unjam_pkg.sv
package i2c_unjam_pkg;

  // Sequencer phases: burst clocking first, then the stop condition.
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LOW,    // burst: SCL pulled, timed
    ST_RISE,   // burst: SCL released, waiting for it to read high
    ST_HIGH,   // burst: SCL high, timed
    ST_SDROP,  // stop: one cycle of SCL low before SDA is pulled
    ST_SLOW,   // stop: SCL and SDA pulled, timed
    ST_SRISE,  // stop: SCL released, waiting for it to read high
    ST_SHOLD,  // stop: SCL high, SDA still pulled, timed
    ST_SREL    // stop: SDA released, timed, then sampled
  } unjam_state_e;

endpackage

// File: rtl/unjam_rst_sync.sv
module unjam_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/unjam_phase_timer.sv
module unjam_phase_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] div_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = load_i | (cnt_q != '0);

  always_comb begin
    if (load_i) cnt_d = div_i;
    else        cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  // R3: a loaded phase counts down by exactly one per cycle
  a_r3_timer_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/unjam_pulse_counter.sv
module unjam_pulse_counter #(
  parameter int PULSES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);

  localparam int CW = $clog2(PULSES + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = clr_i | inc_i;

  always_comb begin
    if (clr_i) cnt_d = '0;
    else       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // the increment applied now completes the final pulse
  assign last_o = (cnt_q == CW'(PULSES - 1));

  // R4: the burst never exceeds the pulse budget
  a_r4_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(PULSES));

endmodule

// File: rtl/unjam_fsm.sv
module unjam_fsm
  import i2c_unjam_pkg::*;
#(
  parameter bit EARLY_EXIT = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic scl_i,
  input  logic sda_i,
  input  logic tmr_zero_i,
  input  logic cnt_last_i,
  output logic tmr_load_o,
  output logic cnt_clr_o,
  output logic cnt_inc_o,
  output logic scl_oe_o,
  output logic sda_oe_o,
  output logic busy_o,
  output logic done_o,
  output logic sda_free_o
);

  unjam_state_e state_q, state_d;
  logic end_q, end_d, end_en;
  logic done_q, done_d;
  logic free_q, free_d, free_en;
  logic stop_now;
  logic finish;

  generate
    if (EARLY_EXIT) begin : g_early
      assign stop_now = cnt_last_i | sda_i;
    end else begin : g_full
      assign stop_now = cnt_last_i;
    end
  endgenerate

  // next-state and control
  always_comb begin
    state_d    = state_q;
    tmr_load_o = 1'b0;
    cnt_clr_o  = 1'b0;
    cnt_inc_o  = 1'b0;
    finish     = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d    = ST_LOW;
        tmr_load_o = 1'b1;
        cnt_clr_o  = 1'b1;
      end
      ST_LOW:   if (tmr_zero_i) state_d = ST_RISE;
      ST_RISE: if (scl_i) begin
        state_d    = ST_HIGH;
        tmr_load_o = 1'b1;
        cnt_inc_o  = 1'b1;
      end
      ST_HIGH: if (tmr_zero_i) begin
        if (end_q) state_d = ST_SDROP;
        else begin
          state_d    = ST_LOW;
          tmr_load_o = 1'b1;
        end
      end
      ST_SDROP: begin
        state_d    = ST_SLOW;
        tmr_load_o = 1'b1;
      end
      ST_SLOW:  if (tmr_zero_i) state_d = ST_SRISE;
      ST_SRISE: if (scl_i) begin
        state_d    = ST_SHOLD;
        tmr_load_o = 1'b1;
      end
      ST_SHOLD: if (tmr_zero_i) begin
        state_d    = ST_SREL;
        tmr_load_o = 1'b1;
      end
      ST_SREL: if (tmr_zero_i) begin
        state_d = ST_IDLE;
        finish  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // flag and result updates
  always_comb begin
    end_en  = cnt_clr_o | cnt_inc_o;
    end_d   = cnt_inc_o & stop_now;
    done_d  = finish;
    free_en = cnt_clr_o | finish;
    free_d  = finish & sda_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      end_q   <= 1'b0;
      done_q  <= 1'b0;
      free_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (end_en)  end_q  <= end_d;
      if (free_en) free_q <= free_d;
    end
  end

  assign scl_oe_o   = (state_q == ST_LOW) || (state_q == ST_SDROP) || (state_q == ST_SLOW);
  assign sda_oe_o   = (state_q == ST_SLOW) || (state_q == ST_SRISE) || (state_q == ST_SHOLD);
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign sda_free_o = free_q;

  // R2: a request while busy leaves the sequence running
  a_r2_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !finish) |=> busy_o);

  // R3: no high phase is timed while SCL is still held low
  a_r3_wait_stretch: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RISE && !scl_i) |=> (state_q == ST_RISE && !scl_oe_o));

  // R5: SDA is pulled only after SCL has already been pulled for a cycle
  a_r5_sda_pull_order: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> ($past(scl_oe_o) && scl_oe_o));

  // R5: SDA is released only while SCL reads high
  a_r5_sda_release_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe_o) |-> scl_i);

  // R6: done is a single-cycle pulse and coincides with idle
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R7: no stale result is shown during a recovery
  a_r7_free_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !sda_free_o);

endmodule

// File: rtl/i2c_unjam.sv
module i2c_unjam #(
  parameter int DIV_W      = 16,
  parameter int PULSES     = 16,
  parameter bit EARLY_EXIT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [DIV_W-1:0] half_div_i,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             sda_free_o
);

  logic rst_n_s;
  logic tmr_load, tmr_zero;
  logic cnt_clr, cnt_inc, cnt_last;

  unjam_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  unjam_phase_timer #(.W(DIV_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .load_i (tmr_load),
    .div_i  (half_div_i),
    .zero_o (tmr_zero)
  );

  unjam_pulse_counter #(.PULSES(PULSES)) u_pulses (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .clr_i  (cnt_clr),
    .inc_i  (cnt_inc),
    .last_o (cnt_last)
  );

  unjam_fsm #(.EARLY_EXIT(EARLY_EXIT)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .start_i    (start_i),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .tmr_zero_i (tmr_zero),
    .cnt_last_i (cnt_last),
    .tmr_load_o (tmr_load),
    .cnt_clr_o  (cnt_clr),
    .cnt_inc_o  (cnt_inc),
    .scl_oe_o   (scl_oe_o),
    .sda_oe_o   (sda_oe_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .sda_free_o (sda_free_o)
  );

endmodule

// File: tb/i2c_unjam_test.sv
module i2c_unjam_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] div = 16'd0;
  logic        scl_in, sda_in;
  logic        scl_oe, sda_oe, busy, done, sda_free;

  int tests = 0, fails = 0;
  int mon_tests = 0, mon_fails = 0;

  // slave model settings: SDA held for kk rising edges, each low phase stretched by ss
  int kk = 0, ss = 0, nn = 0;
  int sl_rises = 0, st_cnt = 0;

  // run observations
  int lo_cnt = 0, hi_cnt = 0, pulses = 0, pulls = 0, rels = 0;
  logic scl_prev = 1'b1, sda_oe_prev = 1'b0, scl_oe_prev = 1'b0, busy_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign scl_in = !scl_oe && (st_cnt == 0);
  assign sda_in = !sda_oe && !(sl_rises < kk);

  i2c_unjam uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .half_div_i(div),
    .scl_i(scl_in), .sda_i(sda_in), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe),
    .busy_o(busy), .done_o(done), .sda_free_o(sda_free)
  );

  // line monitor and slave model, all on the falling edge
  always @(negedge clk) begin
    logic s;
    s = scl_in;
    if (busy && !busy_prev) begin
      pulses = 0; pulls = 0; rels = 0; sl_rises = 0;
    end
    if (!busy) begin
      lo_cnt = 0; hi_cnt = 0;
    end
    // R3: low phase length, checked at each rising SCL while busy
    if (busy && s && !scl_prev) begin
      int exp_lo;
      exp_lo = (sda_oe ? nn + 2 : nn + 1) + ss;
      mon_tests++;
      if (lo_cnt != exp_lo) begin
        mon_fails++;
        $display("FAIL R3 low phase: got %0d expected %0d", lo_cnt, exp_lo);
      end
      lo_cnt = 0;
      if (!sda_oe) pulses++;
      sl_rises++;
    end
    // R3: burst high phase length, checked at each falling SCL
    if (busy && !s && scl_prev && hi_cnt > 0) begin
      int exp_hi;
      exp_hi = (ss == 0) ? nn + 2 : nn + 1;
      mon_tests++;
      if (hi_cnt != exp_hi) begin
        mon_fails++;
        $display("FAIL R3 high phase: got %0d expected %0d", hi_cnt, exp_hi);
      end
      hi_cnt = 0;
    end
    // R5: pull only with SCL pulled before and now, release only with SCL high
    if (sda_oe && !sda_oe_prev) begin
      pulls++;
      mon_tests++;
      if (!(scl_oe_prev && scl_oe && !s)) begin
        mon_fails++;
        $display("FAIL R5 SDA pulled with SCL state %0b/%0b expected 1/1", scl_oe_prev, scl_oe);
      end
    end
    if (!sda_oe && sda_oe_prev) begin
      rels++;
      mon_tests++;
      if (!s) begin
        mon_fails++;
        $display("FAIL R5 SDA released with SCL %0b expected 1", s);
      end
    end
    if (busy && !s) lo_cnt++;
    if (busy && s && !sda_oe) hi_cnt++;
    // stretching slave
    if (scl_oe) st_cnt = ss;
    else if (st_cnt > 0) st_cnt--;
    scl_prev = scl_in; sda_oe_prev = sda_oe; scl_oe_prev = scl_oe; busy_prev = busy;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run(input int n, input int k, input int s, input bit poke);
    int exp_p, cyc;
    bit exp_free;
    exp_p    = (k >= 16) ? 16 : ((k < 1) ? 1 : k);   // R4 early end at first free SDA
    exp_free = (k <= exp_p + 1);                      // burst rises plus the stop rise
    @(negedge clk);
    div = 16'(n); nn = n; kk = k; ss = s;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2 busy after request", busy, 1);
    check(scl_oe == 1'b1, "R2 SCL pulled at start", scl_oe, 1);
    check(sda_free == 1'b0, "R7 result cleared while busy", sda_free, 0);
    cyc = 0;
    while (!done && cyc < 5000) begin
      start = (poke && cyc == 5);
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    check(cyc < 5000, "R6 completion reached", cyc, 0);
    check(busy == 1'b0, "R6 idle at done", busy, 0);
    check(pulses == exp_p, poke ? "R2 R4 pulses with ignored request" : "R4 pulse count", pulses, exp_p);
    check(pulls == 1, "R5 single SDA pull", pulls, 1);
    check(rels == 1, "R5 single SDA release", rels, 1);
    check(sda_free == exp_free, "R7 sda_free", sda_free, exp_free);
    @(negedge clk);
    check(done == 1'b0, "R6 done one cycle", done, 0);
    check(sda_free == exp_free, "R7 result held", sda_free, exp_free);
    check(!scl_oe && !sda_oe, "R1 lines released when idle", {scl_oe, sda_oe}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check({scl_oe, sda_oe, busy, done, sda_free} == 5'b0, "R1 outputs in reset",
          {scl_oe, sda_oe, busy, done, sda_free}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({scl_oe, sda_oe, busy, done, sda_free} == 5'b0, "R1 outputs after reset",
          {scl_oe, sda_oe, busy, done, sda_free}, 0);
    // sweep divider and stuck-slave depth
    for (int n = 0; n < 4; n++) begin
      for (int k = 0; k <= 19; k++) begin
        run(n, (k == 19) ? 100 : k, 0, (k % 3) == 0);
      end
    end
    // clock stretching with free and permanently stuck SDA
    for (int n = 0; n < 3; n++) begin
      for (int s = 1; s <= 3; s++) begin
        run(n, 0, s, 1'b0);
        run(n, 40, s, 1'b1);
      end
    end
    $display("  [TB] %0d tests run, %0d failed", tests + mon_tests, fails + mon_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: run did not finish, got 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", tests + mon_tests + 1, fails + mon_fails + 1);
    $finish;
  end

endmodule